// File: doc/BRIEF.md
# Integer ALU with Condition Flag Update

This block is the arithmetic and logic stage of a small processor datapath. Each cycle it takes a destination operand, a source operand, a 3-bit operation code and the current status word. It returns the computed value, a write-enable for the register file, and the next status word. The status word holds four condition flags: zero, negative, carry and overflow. Every other bit of the status word passes through unchanged. Six operations are supported: add, subtract, compare, bitwise OR, bitwise XOR and bit test. Compare and bit test set the flags without producing a write. During a subtract or a compare, the carry flag holds the borrow.

The datapath is combinational. A registered copy of the status word is also available. It loads the next status word on a rising clock edge when the valid strobe is high, and a parameter can remove it. The reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `flag_alu`

## Requirements
- R1: With op_code 0 (add), result = dst_opnd + src_opnd modulo 2^32 and a write is requested. The carry flag is set exactly when the unsigned sum wraps, that is, when the sum is smaller than either operand.
- R2: For add, the overflow flag is set when both operands have the same bit 31 and bit 31 of the sum differs from it.
- R3: With op_code 1 (subtract), result = dst_opnd − src_opnd and a write is requested. The carry flag is set when src_opnd is greater than dst_opnd as an unsigned value, so it acts as a borrow.
- R4: For subtract, the overflow flag is set when the bit 31 values of the two operands differ and bit 31 of the difference differs from bit 31 of dst_opnd.
- R5: With op_code 2 (compare), all four flags are set exactly as a subtract of src_opnd from dst_opnd would set them. wr_en stays low and result shows dst_opnd.
- R6: With op_code 3 (OR) or op_code 4 (XOR), the bitwise result is written. Zero and negative come from that result, and carry and overflow are cleared.
- R7: With op_code 5 (bit test), zero and negative come from dst_opnd AND src_opnd, and carry and overflow are cleared. wr_en stays low and result shows dst_opnd.
- R8: The flags sit in the status word at these positions: zero at bit 0, negative at bit 1, carry at bit 2, overflow at bit 3. Zero means the 32-bit value is all zeros. Negative is bit 31 of that value.
- R9: Status bits other than the four flags are copied from stat_in to stat_next for every op_code.
- R10: op_code 6 and op_code 7 do not change anything: stat_next equals stat_in, result equals dst_opnd, and wr_en is low.
- R11: wr_en is high only when op_valid is high.
- R12: stat_q is 0 while in reset. On a rising clock edge it loads stat_next when op_valid is high, and otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to clk |
| op_valid | input | 1 | Qualifies the operation: enables the write and the status register load |
| op_code | input | 3 | Operation select: 0 add, 1 subtract, 2 compare, 3 OR, 4 XOR, 5 bit test, 6 and 7 unused |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand |
| stat_in | input | 8 | Current status word |
| result | output | 32 | Computed value, or dst_opnd when no write is requested |
| wr_en | output | 1 | Register file write request |
| stat_next | output | 8 | Next status word (combinational) |
| stat_q | output | 8 | Registered status word |

## Verification
The checker watches several invariants on every cycle. It holds wr_en to op_valid and keeps non-flag status bits equal to stat_in. It confirms that unused codes change nothing and that logic and bit-test operations clear carry and overflow. It checks the zero flag against the written value and the add carry against unsigned wrap. It also checks how the registered status word loads and holds. Only the bench's vector table can show the exact overflow and borrow values at the signed and unsigned boundaries, such as 0x7FFFFFFF + 1, 0x80000000 − 1 and 3 − 5. The same applies to the compare and bit-test flag values, because those depend on specific operand pairs and not on a relation the checker can state in general.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_SUB  = 3'd1;
  localparam logic [2:0] OPC_CMP  = 3'd2;
  localparam logic [2:0] OPC_OR   = 3'd3;
  localparam logic [2:0] OPC_XOR  = 3'd4;
  localparam logic [2:0] OPC_BTST = 3'd5;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_XOR = 2'd1,
    LG_AND = 2'd2
  } logic_sel_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } cond_flags_t;

endpackage

// File: rtl/flag_alu_rst_sync.sv
module flag_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;

  always_comb begin
    b_eff    = b ^ {W{sub}};
    wide_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    res      = wide_sum[W-1:0];
    // carry out for add, inverted carry out (borrow) for subtract
    carry    = wide_sum[W] ^ sub;
    ovf      = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
  end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic_sel_e   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (sel)
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      LG_AND:  res = a & b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/flag_alu_merge.sv
module flag_alu_merge
  import flag_alu_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int ZF_BIT = 0,
  parameter int NF_BIT = 1,
  parameter int CF_BIT = 2,
  parameter int VF_BIT = 3
) (
  input  logic              upd,
  input  cond_flags_t       flags,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_out
);

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == ZF_BIT) begin : g_z
      assign stat_out[i] = upd ? flags.z : stat_in[i];
    end else if (i == NF_BIT) begin : g_n
      assign stat_out[i] = upd ? flags.n : stat_in[i];
    end else if (i == CF_BIT) begin : g_c
      assign stat_out[i] = upd ? flags.c : stat_in[i];
    end else if (i == VF_BIT) begin : g_v
      assign stat_out[i] = upd ? flags.v : stat_in[i];
    end else begin : g_pass
      assign stat_out[i] = stat_in[i];
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STAT_W     = 8,
  parameter int ZF_BIT     = 0,
  parameter int NF_BIT     = 1,
  parameter int CF_BIT     = 2,
  parameter int VF_BIT     = 3,
  parameter bit REG_STATUS = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [STAT_W-1:0] stat_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [STAT_W-1:0] stat_next,
  output logic [STAT_W-1:0] stat_q
);

  localparam int MSB = DATA_W - 1;

  logic              rst_sync_n;
  logic              is_arith;
  logic              is_sub;
  logic              writes;
  logic              upd_flags;
  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] as_res;
  logic              as_carry;
  logic              as_ovf;
  logic [DATA_W-1:0] lg_res;
  logic [DATA_W-1:0] flag_src;
  cond_flags_t       new_flags;

  flag_alu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // operation decode
  always_comb begin
    is_arith  = 1'b0;
    is_sub    = 1'b0;
    writes    = 1'b0;
    upd_flags = 1'b1;
    lg_sel    = LG_OR;
    unique case (op_code)
      OPC_ADD:  begin is_arith = 1'b1; writes = 1'b1; end
      OPC_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; writes = 1'b1; end
      OPC_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; end
      OPC_OR:   begin lg_sel = LG_OR;  writes = 1'b1; end
      OPC_XOR:  begin lg_sel = LG_XOR; writes = 1'b1; end
      OPC_BTST: begin lg_sel = LG_AND; end
      default:  begin upd_flags = 1'b0; end
    endcase
  end

  flag_alu_addsub #(.W(DATA_W)) u_addsub (
    .sub   (is_sub),
    .a     (dst_opnd),
    .b     (src_opnd),
    .res   (as_res),
    .carry (as_carry),
    .ovf   (as_ovf)
  );

  flag_alu_logic #(.W(DATA_W)) u_logic (
    .sel (lg_sel),
    .a   (dst_opnd),
    .b   (src_opnd),
    .res (lg_res)
  );

  // flag generation; logic operations force carry and overflow low
  always_comb begin
    flag_src    = is_arith ? as_res : lg_res;
    new_flags.z = (flag_src == '0);
    new_flags.n = flag_src[MSB];
    new_flags.c = is_arith & as_carry;
    new_flags.v = is_arith & as_ovf;
  end

  flag_alu_merge #(
    .STAT_W (STAT_W),
    .ZF_BIT (ZF_BIT),
    .NF_BIT (NF_BIT),
    .CF_BIT (CF_BIT),
    .VF_BIT (VF_BIT)
  ) u_merge (
    .upd      (upd_flags),
    .flags    (new_flags),
    .stat_in  (stat_in),
    .stat_out (stat_next)
  );

  always_comb begin
    result = writes ? flag_src : dst_opnd;
    wr_en  = op_valid & writes;
  end

  if (REG_STATUS) begin : g_stat_reg
    logic [STAT_W-1:0] stat_d;
    logic [STAT_W-1:0] stat_r;

    always_comb begin
      stat_d = op_valid ? stat_next : stat_r;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        stat_r <= '0;
      end else begin
        stat_r <= stat_d;
      end
    end

    assign stat_q = stat_r;
  end else begin : g_stat_comb
    assign stat_q = stat_next;
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W     = 32,
  parameter int STAT_W     = 8,
  parameter int ZF_BIT     = 0,
  parameter int NF_BIT     = 1,
  parameter int CF_BIT     = 2,
  parameter int VF_BIT     = 3,
  parameter bit REG_STATUS = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] src_opnd,
  input logic [DATA_W-1:0] dst_opnd,
  input logic [STAT_W-1:0] stat_in,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [STAT_W-1:0] stat_next,
  input logic [STAT_W-1:0] stat_q
);

  localparam logic [STAT_W-1:0] FMASK =
    (STAT_W'(1) << ZF_BIT) | (STAT_W'(1) << NF_BIT) |
    (STAT_W'(1) << CF_BIT) | (STAT_W'(1) << VF_BIT);

  // R11
  wr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> op_valid);

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd6 || op_code == 3'd7) |->
      (stat_next == stat_in && result == dst_opnd && !wr_en));

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_next & ~FMASK) == (stat_in & ~FMASK));

  // R6
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3 || op_code == 3'd4 || op_code == 3'd5) |->
      (!stat_next[CF_BIT] && !stat_next[VF_BIT]));

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2 || op_code == 3'd5) |-> (!wr_en && result == dst_opnd));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (stat_next[ZF_BIT] == (result == '0) &&
               stat_next[NF_BIT] == result[DATA_W-1]));

  // R1
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0) |-> (stat_next[CF_BIT] == (result < src_opnd)));

  if (REG_STATUS) begin : g_reg_chk
    // R12
    stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (stat_q == $past(stat_next)));

    // R12
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(stat_q));
  end

endmodule

bind flag_alu flag_alu_chk #(
  .DATA_W     (DATA_W),
  .STAT_W     (STAT_W),
  .ZF_BIT     (ZF_BIT),
  .NF_BIT     (NF_BIT),
  .CF_BIT     (CF_BIT),
  .VF_BIT     (VF_BIT),
  .REG_STATUS (REG_STATUS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .src_opnd  (src_opnd),
  .dst_opnd  (dst_opnd),
  .stat_in   (stat_in),
  .result    (result),
  .wr_en     (wr_en),
  .stat_next (stat_next),
  .stat_q    (stat_q)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] src_opnd;
  logic [31:0] dst_opnd;
  logic [7:0]  stat_in;
  logic [31:0] result;
  logic        wr_en;
  logic [7:0]  stat_next;
  logic [7:0]  stat_q;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  flag_alu u_flag_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .src_opnd  (src_opnd),
    .dst_opnd  (dst_opnd),
    .stat_in   (stat_in),
    .result    (result),
    .wr_en     (wr_en),
    .stat_next (stat_next),
    .stat_q    (stat_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  sin;
    logic [31:0] res;
    logic        wr;
    logic [7:0]  sout;
    logic [23:0] tag;
  } vec_t;

  // flags: Z bit0, N bit1, C bit2, V bit3
  localparam vec_t VECS [0:15] = '{
    '{3'd0, 32'h0000_0001, 32'h0000_0002, 8'hA0, 32'h0000_0003, 1'b1, 8'hA0, "R1 "},
    '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 8'h5F, 32'h0000_0000, 1'b1, 8'h55, "R1 "},
    '{3'd0, 32'h0000_0001, 32'h7FFF_FFFF, 8'h00, 32'h8000_0000, 1'b1, 8'h0A, "R2 "},
    '{3'd0, 32'h8000_0000, 32'h8000_0000, 8'hF0, 32'h0000_0000, 1'b1, 8'hFD, "R2 "},
    '{3'd1, 32'h0000_0003, 32'h0000_0005, 8'h0F, 32'h0000_0002, 1'b1, 8'h00, "R3 "},
    '{3'd1, 32'h0000_0005, 32'h0000_0003, 8'h30, 32'hFFFF_FFFE, 1'b1, 8'h36, "R3 "},
    '{3'd1, 32'h0000_0001, 32'h8000_0000, 8'h00, 32'h7FFF_FFFF, 1'b1, 8'h08, "R4 "},
    '{3'd2, 32'h0000_0007, 32'h0000_0007, 8'hC4, 32'h0000_0007, 1'b0, 8'hC1, "R5 "},
    '{3'd2, 32'h0000_0001, 32'h0000_0000, 8'h00, 32'h0000_0000, 1'b0, 8'h06, "R5 "},
    '{3'd3, 32'h0000_00F0, 32'h8000_0000, 8'h0C, 32'h8000_00F0, 1'b1, 8'h02, "R6 "},
    '{3'd4, 32'h1234_5678, 32'h1234_5678, 8'hAE, 32'h0000_0000, 1'b1, 8'hA1, "R6 "},
    '{3'd5, 32'h8000_0001, 32'h8000_0000, 8'h0D, 32'h8000_0000, 1'b0, 8'h02, "R7 "},
    '{3'd5, 32'h0000_000F, 32'h0000_00F0, 8'h66, 32'h0000_00F0, 1'b0, 8'h61, "R7 "},
    '{3'd6, 32'h0000_0001, 32'hDEAD_BEEF, 8'h5A, 32'hDEAD_BEEF, 1'b0, 8'h5A, "R10"},
    '{3'd7, 32'hFFFF_FFFF, 32'h0000_0000, 8'hFF, 32'h0000_0000, 1'b0, 8'hFF, "R10"},
    '{3'd3, 32'h0000_0000, 32'h0000_0000, 8'h0E, 32'h0000_0000, 1'b1, 8'h01, "R8 "}
  };

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 3'd0;
    src_opnd = '0;
    dst_opnd = '0;
    stat_in  = '0;
    repeat (3) @(negedge clk);
    // R12: reset value of the status register
    check32("R12", "stat_q in reset", {24'h0, stat_q}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      op_valid = 1'b1;
      op_code  = VECS[i].op;
      src_opnd = VECS[i].src;
      dst_opnd = VECS[i].dst;
      stat_in  = VECS[i].sin;
      #1;
      check32(string'(VECS[i].tag), "result", result, VECS[i].res);
      check32(string'(VECS[i].tag), "wr_en", {31'h0, wr_en}, {31'h0, VECS[i].wr});
      check32(string'(VECS[i].tag), "stat_next", {24'h0, stat_next}, {24'h0, VECS[i].sout});
      @(negedge clk);
      // R12: loaded on the edge with op_valid high
      check32("R12", "stat_q load", {24'h0, stat_q}, {24'h0, VECS[i].sout});
    end

    // R11: no write without op_valid; R12: stat_q holds
    op_valid = 1'b0;
    op_code  = 3'd0;
    src_opnd = 32'h1;
    dst_opnd = 32'h2;
    stat_in  = 8'hF0;
    #1;
    check32("R11", "wr_en idle", {31'h0, wr_en}, 32'h0);
    check32("R9", "stat_next idle", {24'h0, stat_next}, 32'h0000_00F0);
    @(negedge clk);
    check32("R12", "stat_q hold", {24'h0, stat_q}, 32'h0000_0001);

    // R12: asynchronous reset clears the register mid-run
    rst_n = 1'b0;
    #1;
    check32("R12", "stat_q async reset", {24'h0, stat_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule